// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Front End

This block is the memory-mapped control and status face of a simple serial port that only carries 8 data bits, no parity and one stop bit. A synchronous bus reads and writes eight byte-wide registers placed on word boundaries:

- four fixed identification bytes;
- a data port;
- a status byte;
- the two halves of a 16-bit baud divisor, which drives the tick generator.

Behind the data port sit a small receive FIFO and a one-byte transmit holding stage. The receive FIFO is filled by an external deserializer, and the holding stage is emptied by an external serializer.

The status byte packs three kinds of bits together:

- the two interrupt enables, which software can write;
- the receive level flags and the transmit-empty flag, which are read-only;
- two sticky receive error flags, which software clears by writing a zero into them.

Receive and transmit share one interrupt line.

The transmit holding stage is a two-state machine:

- In state EMPTY, the load transition (a bus write to the data port) captures the byte and moves to HELD.
- In state HELD, the byte is offered to the serializer. The take transition (the serializer accepting it) returns the machine to EMPTY.

Top module: `uart_regif`

## Requirements
- R1: After reset, the status byte reads 0xA0. That is: TX empty (bit7) and RX empty (bit5) are 1, and all other bits are 0. In addition, irq is 0, tx_valid is 0 and baud_div equals BAUD_RESET.
- R2: Word offsets 0, 4, 8 and 12 read bytes 0 to 3 of ID_VALUE, least significant byte first. Writes to these offsets have no effect.
- R3: Offset 24 holds baud_div[7:0] and offset 28 holds baud_div[15:8]. Both are readable and writable, and baud_div follows them one cycle after the write.
- R4: Each push on rx_valid stores rx_byte in a FIFO of RX_DEPTH entries, and reads of offset 16 return the bytes in arrival order, removing one per read. The status flags track the fill level:
  - bit3 is 1 when the FIFO is full;
  - bit4 is 1 when exactly one entry is free;
  - bit5 is 1 when the FIFO is empty.
- R5: A read of offset 16 while the FIFO is empty returns the last byte removed (0 if none has been removed since reset) and changes no state.
- R6: A push while the FIFO is full drops the byte and sets the sticky overrun flag (status bit1).
- R7: A push with rx_frame_err high sets the sticky frame-error flag (status bit0). The byte is still stored.
- R8: A write to offset 20 clears an error flag where the written bit is 0 and leaves it unchanged where the bit is 1.
- R9: A write to offset 20 loads the RX enable from bit2 and the TX enable from bit6. Written values of bits 3, 4, 5 and 7 are ignored.
- R10: A write to offset 16 in state EMPTY loads the holding stage. The load raises tx_valid with that byte and clears status bit7. A write in state HELD is ignored. tx_take in state HELD returns the stage to EMPTY.
- R11: irq is 1 exactly when either of these holds:
  - the TX enable is set and the holding stage is EMPTY;
  - the RX enable is set and there is data in the FIFO or an error flag is set.
- R12: Addresses with nonzero bits [1:0] read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| rx_valid | input | 1 | Deserializer delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_frame_err | input | 1 | Stop bit was missing for this byte |
| tx_valid | output | 1 | Holding stage has a byte for the serializer |
| tx_data | output | 8 | Byte in the holding stage |
| tx_take | input | 1 | Serializer accepts the held byte |
| baud_div | output | 16 | Baud divisor for the tick generator |
| irq | output | 1 | Combined receive/transmit interrupt |

## Verification
The assertions take for granted three things about the inputs:

- tx_take is raised only while tx_valid is high;
- rx_valid is a single-cycle pulse per byte;
- bus inputs are never unknown after reset.

The directed tasks respect these conditions:

- The serializer pulse is issued only after a load has been observed.
- Every received byte is a one-cycle strobe applied on the falling edge.
- Idle bus cycles drive bus_sel low rather than leaving it floating.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
    // word index = byte address [4:2]
    localparam logic [2:0] IDX_DATA = 3'd4;
    localparam logic [2:0] IDX_STAT = 3'd5;
    localparam logic [2:0] IDX_BDL  = 3'd6;
    localparam logic [2:0] IDX_BDH  = 3'd7;

    // status bit positions (decoded by software)
    localparam int ST_FERR    = 0;
    localparam int ST_OERR    = 1;
    localparam int ST_RXIE    = 2;
    localparam int ST_RXFULL  = 3;
    localparam int ST_RXONE   = 4;
    localparam int ST_RXEMPTY = 5;
    localparam int ST_TXIE    = 6;
    localparam int ST_TXEMPTY = 7;

    typedef enum logic {
        TXH_EMPTY = 1'b0,
        TXH_HELD  = 1'b1
    } txh_state_e;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         one_free,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full     = (count == CNT_W'(DEPTH));
    assign one_free = (count == CNT_W'(DEPTH - 1));
    assign empty    = (count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign head     = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_regif_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         take,
    output logic         tx_valid,
    output logic [W-1:0] tx_data,
    output logic         hold_empty
);
    txh_state_e   state_q, state_d;
    logic [W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXH_EMPTY: if (load) state_d = TXH_HELD;
            TXH_HELD:  if (take) state_d = TXH_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TXH_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TXH_EMPTY && load) data_q <= load_data;
        end
    end

    always_comb begin
        tx_valid   = (state_q == TXH_HELD);
        hold_empty = (state_q == TXH_EMPTY);
        tx_data    = data_q;
    end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int          RX_DEPTH   = 4,
    parameter logic [31:0] ID_VALUE   = 32'h5A01_C3E7,
    parameter logic [15:0] BAUD_RESET = 16'h0035
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_frame_err,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_take,
    output logic [15:0] baud_div,
    output logic        irq
);
    logic       word_ok, wr_en, rd_en;
    logic [2:0] idx;
    logic       stat_wr, data_wr, data_rd, bdl_wr, bdh_wr;
    logic [7:0] rx_head, last_q;
    logic       rx_full, rx_one, rx_empty, rx_pop;
    logic       hold_empty;
    logic       ferr_q, oerr_q, rxie_q, txie_q;
    logic [7:0] baud_lo_q, baud_hi_q;
    logic [7:0] status_byte;

    assign word_ok = (bus_addr[1:0] == 2'b00);
    assign idx     = bus_addr[4:2];
    assign wr_en   = bus_sel && bus_we && word_ok;
    assign rd_en   = bus_sel && !bus_we && word_ok;
    assign stat_wr = wr_en && (idx == IDX_STAT);
    assign data_wr = wr_en && (idx == IDX_DATA);
    assign bdl_wr  = wr_en && (idx == IDX_BDL);
    assign bdh_wr  = wr_en && (idx == IDX_BDH);
    assign data_rd = rd_en && (idx == IDX_DATA);
    assign rx_pop  = data_rd && !rx_empty;

    uart_rx_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_valid), .push_data(rx_byte), .pop(rx_pop),
        .head(rx_head), .full(rx_full), .one_free(rx_one), .empty(rx_empty)
    );

    uart_tx_hold #(.W(8)) u_txh (
        .clk(clk), .rst_n(rst_n),
        .load(data_wr), .load_data(bus_wdata), .take(tx_take),
        .tx_valid(tx_valid), .tx_data(tx_data), .hold_empty(hold_empty)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ferr_q    <= 1'b0;
            oerr_q    <= 1'b0;
            rxie_q    <= 1'b0;
            txie_q    <= 1'b0;
            last_q    <= '0;
            baud_lo_q <= BAUD_RESET[7:0];
            baud_hi_q <= BAUD_RESET[15:8];
        end else begin
            ferr_q <= (rx_valid && rx_frame_err) ||
                      (ferr_q && (!stat_wr || bus_wdata[ST_FERR]));
            oerr_q <= (rx_valid && rx_full) ||
                      (oerr_q && (!stat_wr || bus_wdata[ST_OERR]));
            if (stat_wr) begin
                rxie_q <= bus_wdata[ST_RXIE];
                txie_q <= bus_wdata[ST_TXIE];
            end
            if (rx_pop) last_q    <= rx_head;
            if (bdl_wr) baud_lo_q <= bus_wdata;
            if (bdh_wr) baud_hi_q <= bus_wdata;
        end
    end

    always_comb begin
        status_byte             = '0;
        status_byte[ST_FERR]    = ferr_q;
        status_byte[ST_OERR]    = oerr_q;
        status_byte[ST_RXIE]    = rxie_q;
        status_byte[ST_RXFULL]  = rx_full;
        status_byte[ST_RXONE]   = rx_one;
        status_byte[ST_RXEMPTY] = rx_empty;
        status_byte[ST_TXIE]    = txie_q;
        status_byte[ST_TXEMPTY] = hold_empty;
    end

    always_comb begin
        bus_rdata = '0;
        if (word_ok) begin
            unique case (idx)
                3'd0, 3'd1, 3'd2, 3'd3: bus_rdata = ID_VALUE[8*idx[1:0] +: 8];
                IDX_DATA: bus_rdata = rx_empty ? last_q : rx_head;
                IDX_STAT: bus_rdata = status_byte;
                IDX_BDL:  bus_rdata = baud_lo_q;
                IDX_BDH:  bus_rdata = baud_hi_q;
            endcase
        end
    end

    assign baud_div = {baud_hi_q, baud_lo_q};
    assign irq = (txie_q && hold_empty) ||
                 (rxie_q && (!rx_empty || ferr_q || oerr_q));
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] st,
    input logic       rx_valid,
    input logic       tx_valid,
    input logic       tx_take,
    input logic [7:0] tx_data,
    input logic       irq,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [4:0] bus_addr
);
    // R4
    fifo_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st[3] && st[5]));
    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && st[3]) |=> st[1]);
    // R8
    ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st[0] && !(bus_sel && bus_we && bus_addr == 5'd20)) |=> st[0]);
    // R10
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_take) |=> (tx_valid && $stable(tx_data)));
    // R10
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_take) |=> !tx_valid);
    // R11
    rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st[2] && !st[5]) |-> irq);
    // R11
    tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st[6] && st[7]) |-> irq);
endmodule

bind uart_regif uart_regif_chk chk_i (
    .clk(clk), .rst_n(rst_n), .st(status_byte), .rx_valid(rx_valid),
    .tx_valid(tx_valid), .tx_take(tx_take), .tx_data(tx_data), .irq(irq),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr)
);

// File: tb/uart_regif_tb_top.sv
`timescale 1ns/1ps
module uart_regif_tb_top;
    localparam logic [31:0] IDV = 32'h5A01_C3E7;
    localparam logic [15:0] BRST = 16'h0035;
    localparam logic [4:0] A_DATA = 5'd16, A_STAT = 5'd20, A_BDL = 5'd24, A_BDH = 5'd28;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 0, bus_we = 0, rx_valid = 0, rx_frame_err = 0, tx_take = 0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, rx_byte = '0, bus_rdata, tx_data;
    logic tx_valid, irq;
    logic [15:0] baud_div;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_regif dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_frame_err(rx_frame_err),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_take(tx_take),
        .baud_div(baud_div), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] d);
        @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_sel = 0;
    endtask

    task automatic rx_send(logic [7:0] b, logic fe);
        @(negedge clk); rx_valid = 1; rx_byte = b; rx_frame_err = fe;
        @(posedge clk); #1 rx_valid = 0; rx_frame_err = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(A_STAT, v); chk("R1 status", v, 8'hA0);
        chk("R1 irq", irq, 0); chk("R1 tx_valid", tx_valid, 0);
        chk("R1 baud", baud_div, BRST);
        for (int i = 0; i < 4; i++) begin
            rd(5'(4*i), v); chk("R2 id byte", v, IDV[8*i +: 8]);
        end
        wr(5'd0, 8'h00); rd(5'd0, v); chk("R2 id write ignored", v, IDV[7:0]);
    endtask

    task automatic t_baud();
        logic [7:0] v;
        wr(A_BDL, 8'h34); wr(A_BDH, 8'h12);
        chk("R3 baud_div", baud_div, 16'h1234);
        rd(A_BDL, v); chk("R3 low", v, 8'h34);
        rd(A_BDH, v); chk("R3 high", v, 8'h12);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(5'd17, 8'h55); chk("R12 no tx load", tx_valid, 0);
        wr(5'd22, 8'h44); rd(A_STAT, v); chk("R12 status untouched", v, 8'hA0);
        rd(5'd25, v); chk("R12 read zero", v, 8'h00);
    endtask

    task automatic t_rx_fifo();
        logic [7:0] v;
        rx_send(8'h11, 0); rx_send(8'h22, 0); rx_send(8'h33, 0);
        rd(A_STAT, v); chk("R4 one free", v, 8'h90);
        rx_send(8'h44, 0);
        rd(A_STAT, v); chk("R4 full", v, 8'h88);
        for (int i = 1; i <= 4; i++) begin
            rd(A_DATA, v); chk("R4 order", v, 8'(8'h11 * i));
        end
        rd(A_STAT, v); chk("R4 empty again", v, 8'hA0);
        rd(A_DATA, v); chk("R5 empty read last", v, 8'h44);
        rd(A_STAT, v); chk("R5 no state change", v, 8'hA0);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        for (int i = 0; i < 4; i++) rx_send(8'(8'hB0 + i), 0);
        rx_send(8'h99, 0);
        rd(A_STAT, v); chk("R6 overrun flag", v, 8'h8A);
        for (int i = 0; i < 4; i++) begin
            rd(A_DATA, v); chk("R6 kept bytes", v, 8'(8'hB0 + i));
        end
        rd(A_STAT, v); chk("R6 dropped byte, sticky", v, 8'hA2);
        wr(A_STAT, 8'h00); rd(A_STAT, v); chk("R8 clear overrun", v, 8'hA0);
    endtask

    task automatic t_frame();
        logic [7:0] v;
        rx_send(8'h5C, 1);
        rd(A_STAT, v); chk("R7 frame flag", v, 8'h81);
        wr(A_STAT, 8'h01); rd(A_STAT, v); chk("R8 write one keeps", v, 8'h81);
        rd(A_DATA, v); chk("R7 byte stored", v, 8'h5C);
        wr(A_STAT, 8'h00); rd(A_STAT, v); chk("R8 write zero clears", v, 8'hA0);
    endtask

    task automatic t_ro_bits();
        logic [7:0] v;
        wr(A_STAT, 8'hFC); rd(A_STAT, v); chk("R9 enables set, ro ignored", v, 8'hE4);
        chk("R11 tx irq idle", irq, 1);
        wr(A_STAT, 8'h00); chk("R11 irq off", irq, 0);
    endtask

    task automatic t_tx();
        logic [7:0] v;
        wr(A_DATA, 8'hA5);
        chk("R10 tx_valid", tx_valid, 1); chk("R10 tx_data", tx_data, 8'hA5);
        rd(A_STAT, v); chk("R10 tx empty low", v, 8'h20);
        wr(A_DATA, 8'h3C); chk("R10 write while held ignored", tx_data, 8'hA5);
        wr(A_STAT, 8'h40); chk("R11 no tx irq while held", irq, 0);
        @(negedge clk); tx_take = 1; @(posedge clk); #1 tx_take = 0;
        chk("R10 released", tx_valid, 0);
        chk("R11 tx irq after release", irq, 1);
        rd(A_STAT, v); chk("R10 tx empty back", v, 8'hE0);
        wr(A_STAT, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(A_STAT, 8'h04); chk("R11 rx idle no irq", irq, 0);
        rx_send(8'h61, 0); chk("R11 rx data irq", irq, 1);
        rd(A_DATA, v); chk("R11 drained no irq", irq, 0);
        rx_send(8'h62, 1); rd(A_DATA, v);
        chk("R11 error-only irq", irq, 1);
        wr(A_STAT, 8'h04); chk("R11 cleared error", irq, 0);
        wr(A_STAT, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset(); t_baud(); t_unmapped(); t_rx_fifo(); t_overrun();
        t_frame(); t_ro_bits(); t_tx(); t_irq();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule